// File: doc/BRIEF.md
# CPU Reset and Bus Hold Interlock

This block sits between the chip's reset request sources, a bus master that wants the processor to float its bus, and the processor itself. It drives the processor's reset line and its bus hold line, and it guarantees that the two are never asserted together. A reset that is requested while the processor is held waits until the hold is released. A hold that is requested during a reset pulse waits until the pulse is over. Every soft reset pulse lasts a fixed number of clock cycles, and it ends on a rising clock edge.

A reset request can come from several general sources and from one fast-reset port bit. The fast-reset bit passes only while its enable input is high. Requests are latched until they are served, so a short request is never lost. Requests that arrive while a pulse is running are folded into that pulse. A mode input changes the policy so that a reset is issued only out of the held state. The bus is first taken into hold, and then the hold is swapped for the reset pulse on a single clock edge.

Top module: `cpu_rst_hold_ilk`

## Requirements
- R1: `cpuReset` and `cpuHold` are never both high in any cycle.
- R2: With `holdOnlyMode` low, a reset request made while `cpuHold` is high does not raise `cpuReset` until `holdReq` has been sampled low. `cpuReset` then rises on the same clock edge at which `cpuHold` falls.
- R3: A `holdReq` sampled high while `cpuReset` is high does not raise `cpuHold` until the pulse ends. If `holdReq` is still high at that point, `cpuHold` rises on the same edge at which `cpuReset` falls.
- R4: Every reset pulse keeps `cpuReset` high for exactly `PULSE_LEN` clock cycles (default 16). It rises and falls only on rising clock edges.
- R5: When the block is idle, a reset request sampled at a rising edge raises `cpuReset` at that same edge, and a `holdReq` sampled high raises `cpuHold` at that same edge.
- R6: When a reset request and `holdReq` are first sampled in the same cycle while both outputs are low, the reset is served first.
- R7: `fastRstReq` causes a reset only while `fastRstEn` is high. With `fastRstEn` low it is ignored and is not latched.
- R8: A reset request that cannot be served at once stays pending after its input drops, and it is served later.
- R9: Requests made while `cpuReset` is high neither lengthen nor restart the running pulse, and they do not cause a second pulse after it ends.
- R10: With `holdOnlyMode` high, a pending reset is served only out of the held state. `cpuHold` falls on the edge at which `cpuReset` rises. If `holdReq` is still high when the pulse ends, `cpuHold` returns.
- R11: After `rstN` is deasserted and before any request, `cpuReset` and `cpuHold` are both low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock; all state changes on its rising edge |
| rstN | input | 1 | Asynchronous active-low block reset |
| srcRstReq | input | NUM_SRC | Level soft-reset requests from general sources |
| fastRstReq | input | 1 | Level soft-reset request from the fast-reset port bit |
| fastRstEn | input | 1 | High lets `fastRstReq` act as a reset source |
| holdOnlyMode | input | 1 | High: issue a reset only out of the held state |
| holdReq | input | 1 | Bus master's request to hold the processor |
| cpuReset | output | 1 | Reset line to the processor |
| cpuHold | output | 1 | Hold line to the processor |

## Verification
The bench builds the block with `PULSE_LEN` = 16 and `NUM_SRC` = 3. With these values it can measure the shortest legal pulse length cycle by cycle. It can also raise a second general source in the middle of a running pulse, which exercises the merging rule. With three sources, requests from different inputs can overlap. The bench also drives every ordering of a reset request against a hold request, in both policy modes.

// File: rtl/cpu_rst_hold_pkg.sv
package cpu_rst_hold_pkg;

  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_HOLD  = 2'd1,
    ST_RESET = 2'd2
  } ilkState_t;

  typedef struct packed {
    logic startPulse;
    logic pulseActive;
  } ilkStrobe_t;

endpackage

// File: rtl/cpu_rst_hold_dp.sv
module cpu_rst_hold_dp
  import cpu_rst_hold_pkg::*;
#(
  parameter int NUM_SRC   = 3,
  parameter int PULSE_LEN = 16
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic [NUM_SRC-1:0] srcRstReq,
  input  logic               fastRstReq,
  input  logic               fastRstEn,
  input  ilkStrobe_t         strobe,
  output logic               rstNow,
  output logic               pulseDone
);

  localparam int CNT_W = $clog2(PULSE_LEN + 1);
  localparam logic [CNT_W-1:0] CNT_LOAD = CNT_W'(PULSE_LEN - 1);

  logic             anyReq;
  logic             pending;
  logic [CNT_W-1:0] pulseCnt;

  // Merge all sources; the fast-reset bit is gated by its enable.
  assign anyReq = (|srcRstReq) | (fastRstReq & fastRstEn);

  // Requests are only accepted outside a running pulse.
  assign rstNow    = ~strobe.pulseActive & (pending | anyReq);
  assign pulseDone = strobe.pulseActive & (pulseCnt == '0);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      pending <= 1'b0;
    end else begin
      pending <= (pending | (anyReq & ~strobe.pulseActive)) & ~strobe.startPulse;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      pulseCnt <= '0;
    end else if (strobe.startPulse) begin
      pulseCnt <= CNT_LOAD;
    end else if (pulseCnt != '0) begin
      pulseCnt <= pulseCnt - 1'b1;
    end
  end

  // R8: a latched request survives until a pulse starts
  assert_pending_kept_R8 : assert property (@(posedge clk) disable iff (!rstN)
    (pending && !strobe.startPulse) |=> pending);

  // R7: a disabled fast-reset bit alone never yields a reset request
  assert_fast_gated_R7 : assert property (@(posedge clk) disable iff (!rstN)
    (!fastRstEn && srcRstReq == '0 && !pending) |-> !rstNow);

  // R9: no new request is accepted during a pulse
  assert_no_merge_latch_R9 : assert property (@(posedge clk) disable iff (!rstN)
    strobe.pulseActive |=> !pending);

endmodule

// File: rtl/cpu_rst_hold_ctl.sv
module cpu_rst_hold_ctl
  import cpu_rst_hold_pkg::*;
#(
  parameter int PULSE_LEN = 16
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       holdOnlyMode,
  input  logic       holdReq,
  input  logic       rstNow,
  input  logic       pulseDone,
  output ilkStrobe_t strobe,
  output logic       cpuReset,
  output logic       cpuHold
);

  localparam int RUN_W = $clog2(PULSE_LEN + 1) + 1;

  ilkState_t state, nextState;

  always_comb begin
    nextState = state;
    unique case (state)
      ST_IDLE: begin
        if (rstNow && !holdOnlyMode)  nextState = ST_RESET;
        else if (holdReq)             nextState = ST_HOLD;
      end
      ST_HOLD: begin
        if (rstNow && (holdOnlyMode || !holdReq)) nextState = ST_RESET;
        else if (!holdReq)                        nextState = ST_IDLE;
      end
      ST_RESET: begin
        if (pulseDone) nextState = holdReq ? ST_HOLD : ST_IDLE;
      end
      default: nextState = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) state <= ST_IDLE;
    else       state <= nextState;
  end

  assign strobe.startPulse  = (nextState == ST_RESET) && (state != ST_RESET);
  assign strobe.pulseActive = (state == ST_RESET);
  assign cpuReset = (state == ST_RESET);
  assign cpuHold  = (state == ST_HOLD);

  // Run-length tracker for the pulse-width check.
  logic [RUN_W-1:0] runLen;
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                             runLen <= '0;
    else if (!cpuReset)                    runLen <= '0;
    else if (runLen < RUN_W'(PULSE_LEN))   runLen <= runLen + 1'b1;
  end

  assert_never_both_R1 : assert property (@(posedge clk) disable iff (!rstN)
    !(cpuReset && cpuHold));

  assert_reset_waits_hold_R2 : assert property (@(posedge clk) disable iff (!rstN)
    (cpuHold && holdReq && !holdOnlyMode) |=> !cpuReset);

  assert_hold_waits_reset_R3 : assert property (@(posedge clk) disable iff (!rstN)
    (cpuReset && !pulseDone) |=> (cpuReset && !cpuHold));

  assert_min_width_R4 : assert property (@(posedge clk) disable iff (!rstN)
    $fell(cpuReset) |-> (runLen >= RUN_W'(PULSE_LEN)));

  assert_hold_only_R10 : assert property (@(posedge clk) disable iff (!rstN)
    (holdOnlyMode && !cpuReset && !cpuHold) |=> !cpuReset);

endmodule

// File: rtl/cpu_rst_hold_ilk.sv
module cpu_rst_hold_ilk
  import cpu_rst_hold_pkg::*;
#(
  parameter int NUM_SRC   = 3,
  parameter int PULSE_LEN = 16
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic [NUM_SRC-1:0] srcRstReq,
  input  logic               fastRstReq,
  input  logic               fastRstEn,
  input  logic               holdOnlyMode,
  input  logic               holdReq,
  output logic               cpuReset,
  output logic               cpuHold
);

  ilkStrobe_t strobe;
  logic       rstNow;
  logic       pulseDone;

  cpu_rst_hold_dp #(.NUM_SRC(NUM_SRC), .PULSE_LEN(PULSE_LEN)) dp_i (
    .clk        (clk),
    .rstN       (rstN),
    .srcRstReq  (srcRstReq),
    .fastRstReq (fastRstReq),
    .fastRstEn  (fastRstEn),
    .strobe     (strobe),
    .rstNow     (rstNow),
    .pulseDone  (pulseDone)
  );

  cpu_rst_hold_ctl #(.PULSE_LEN(PULSE_LEN)) ctl_i (
    .clk          (clk),
    .rstN         (rstN),
    .holdOnlyMode (holdOnlyMode),
    .holdReq      (holdReq),
    .rstNow       (rstNow),
    .pulseDone    (pulseDone),
    .strobe       (strobe),
    .cpuReset     (cpuReset),
    .cpuHold      (cpuHold)
  );

endmodule

// File: tb/cpu_rst_hold_ilk_tb.sv
module cpu_rst_hold_ilk_tb_top;

  localparam int CLK_PERIOD = 10;
  localparam int NUM_SRC    = 3;
  localparam int PULSE_LEN  = 16;

  logic               clk = 1'b0;
  logic               rstN = 1'b0;
  logic [NUM_SRC-1:0] srcRstReq = '0;
  logic               fastRstReq = 1'b0;
  logic               fastRstEn = 1'b0;
  logic               holdOnlyMode = 1'b0;
  logic               holdReq = 1'b0;
  logic               cpuReset;
  logic               cpuHold;

  int checks = 0;
  int errors = 0;
  int cycles = 0;
  bit finished = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  cpu_rst_hold_ilk #(.NUM_SRC(NUM_SRC), .PULSE_LEN(PULSE_LEN)) dut_i (
    .clk(clk), .rstN(rstN), .srcRstReq(srcRstReq), .fastRstReq(fastRstReq),
    .fastRstEn(fastRstEn), .holdOnlyMode(holdOnlyMode), .holdReq(holdReq),
    .cpuReset(cpuReset), .cpuHold(cpuHold)
  );

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic step(input int n = 1);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic expectOut(input string tag, input logic expRst, input logic expHold);
    chk(cpuReset == expRst, {tag, " cpuReset"}, int'(cpuReset), int'(expRst));
    chk(cpuHold == expHold, {tag, " cpuHold"}, int'(cpuHold), int'(expHold));
  endtask

  // Counts the remaining high cycles of a pulse (current sample included).
  task automatic measurePulse(output int len, output int holdSeen);
    len = 0; holdSeen = 0;
    while (cpuReset && len < 100) begin
      len++;
      if (cpuHold) holdSeen++;
      step();
    end
  endtask

  // R1 monitor on every sample
  always @(negedge clk) begin
    if (rstN && cpuReset && cpuHold) begin
      checks++; errors++;
      $display("FAIL R1: actual=both high expected=not both");
    end
  end

  always @(posedge clk) begin
    cycles++;
    if (cycles > 20000 && !finished) begin
      errors++;
      $display("FAIL watchdog: actual=%0d cycles expected=completion", cycles);
      $display("Result: errors=%0d of %0d checks", errors, checks + 1);
      $finish;
    end
  end

  task automatic t_reset_state();
    expectOut("R11 after reset", 1'b0, 1'b0);
  endtask

  task automatic t_basic_pulse();
    int len, hs;
    srcRstReq[0] = 1'b1; step();
    expectOut("R5 reset latency", 1'b1, 1'b0);
    srcRstReq[0] = 1'b0;
    measurePulse(len, hs);
    chk(len == PULSE_LEN, "R4 pulse length", len, PULSE_LEN);
    expectOut("R4 after pulse", 1'b0, 1'b0);
  endtask

  task automatic t_basic_hold();
    holdReq = 1'b1; step();
    expectOut("R5 hold latency", 1'b0, 1'b1);
    holdReq = 1'b0; step();
    expectOut("R5 hold release", 1'b0, 1'b0);
  endtask

  task automatic t_reset_during_hold();
    int len, hs;
    holdReq = 1'b1; step();
    srcRstReq[1] = 1'b1; step();
    srcRstReq[1] = 1'b0; step(3);
    expectOut("R2 R8 deferred in hold", 1'b0, 1'b1);
    holdReq = 1'b0; step();
    expectOut("R2 swap on hold release", 1'b1, 1'b0);
    measurePulse(len, hs);
    chk(len == PULSE_LEN, "R8 latched pulse length", len, PULSE_LEN);
  endtask

  task automatic t_hold_during_reset();
    int len, hs;
    srcRstReq[0] = 1'b1; step();
    srcRstReq[0] = 1'b0; holdReq = 1'b1;
    measurePulse(len, hs);
    chk(len == PULSE_LEN, "R3 pulse not cut by hold", len, PULSE_LEN);
    chk(hs == 0, "R3 hold seen during pulse", hs, 0);
    expectOut("R3 hold after pulse", 1'b0, 1'b1);
    holdReq = 1'b0; step();
  endtask

  task automatic t_merge();
    int len, hs, extra;
    srcRstReq[0] = 1'b1; step();
    srcRstReq[0] = 1'b0; step(5);
    srcRstReq[2] = 1'b1; step(2);
    srcRstReq[2] = 1'b0;
    measurePulse(len, hs);
    chk(len == PULSE_LEN - 7, "R9 remaining pulse length", len, PULSE_LEN - 7);
    extra = 0;
    for (int i = 0; i < 20; i++) begin
      if (cpuReset) extra++;
      step();
    end
    chk(extra == 0, "R9 no second pulse", extra, 0);
  endtask

  task automatic t_priority();
    int len, hs;
    srcRstReq[1] = 1'b1; holdReq = 1'b1; step();
    expectOut("R6 reset wins", 1'b1, 1'b0);
    srcRstReq[1] = 1'b0;
    measurePulse(len, hs);
    chk(len == PULSE_LEN, "R6 pulse length", len, PULSE_LEN);
    expectOut("R6 hold after", 1'b0, 1'b1);
    holdReq = 1'b0; step();
  endtask

  task automatic t_fast();
    int len, hs, seen;
    fastRstEn = 1'b0; fastRstReq = 1'b1;
    seen = 0;
    for (int i = 0; i < 3; i++) begin step(); if (cpuReset) seen++; end
    fastRstReq = 1'b0;
    for (int i = 0; i < 3; i++) begin step(); if (cpuReset) seen++; end
    chk(seen == 0, "R7 disabled fast reset", seen, 0);
    fastRstEn = 1'b1; fastRstReq = 1'b1; step();
    expectOut("R7 enabled fast reset", 1'b1, 1'b0);
    fastRstReq = 1'b0;
    measurePulse(len, hs);
    chk(len == PULSE_LEN, "R7 fast pulse length", len, PULSE_LEN);
    fastRstEn = 1'b0;
  endtask

  task automatic t_hold_only();
    int len, hs;
    holdOnlyMode = 1'b1;
    srcRstReq[0] = 1'b1; step();
    srcRstReq[0] = 1'b0; step(3);
    expectOut("R10 waits for hold", 1'b0, 1'b0);
    holdReq = 1'b1; step();
    expectOut("R10 hold first", 1'b0, 1'b1);
    step();
    expectOut("R10 swap to reset", 1'b1, 1'b0);
    measurePulse(len, hs);
    chk(len == PULSE_LEN, "R10 pulse length", len, PULSE_LEN);
    chk(hs == 0, "R10 no hold in pulse", hs, 0);
    expectOut("R10 hold returns", 1'b0, 1'b1);
    holdReq = 1'b0; step();
    expectOut("R10 idle", 1'b0, 1'b0);
    holdOnlyMode = 1'b0;
  endtask

  initial begin
    step(3);
    rstN = 1'b1;
    step(2);
    t_reset_state();
    t_basic_pulse();
    t_basic_hold();
    t_reset_during_hold();
    t_hold_during_reset();
    t_merge();
    t_priority();
    t_fast();
    t_hold_only();
    step(2);
    finished = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule